// File: doc/BRIEF.md
# Vectored Interrupt Controller with Context Save

This unit handles interrupts for a small 4-bit processor core. It has three request sources: an edge on an external pin, an underflow of timer 1 and an underflow of timer 2. Each source sets a request flag. The flag stays set until the unit services it or software clears it. A per-source enable bit and a global enable flag decide whether a pending request can be serviced. The unit accepts a request only at an instruction boundary, which the core marks with `instr_done`.

When the unit takes an interrupt, it pulses `take_irq` and drives a fixed vector address in page 1. It captures the current program counter into a return-address register and clears the global enable. It clears the request flag of the serviced source and no other. It also copies the core's context word (data pointer, carry, skip, A and B registers) into a single-entry shadow store. An RTI strobe issued while the unit is servicing returns it to normal running. On that strobe the unit drives the saved context back on `ctx_out` and pulses `ctx_restore`.

The unit has two state machines. The global enable machine has three states. `GE_OFF` moves to `GE_ARMED` on EI. `GE_ARMED` moves to `GE_ON` at the next instruction boundary. Any state moves to `GE_OFF` on DI or on a take. The service machine has two states. `CTL_RUN` moves to `CTL_ISR` on a take, and `CTL_ISR` moves back to `CTL_RUN` on RTI.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `gie` is 0, `pend` is 000, `take_irq` is 0 and `ctx_restore` is 0.
- R2: `pend` bit 0 is the external source, bit 1 is timer 1 and bit 2 is timer 2. A timer pulse sets its bit. The pin sets bit 0 on a rising edge when `edge_sel`=0 and on a falling edge when `edge_sel`=1. The opposite edge has no effect. A flag is set whatever the enables are.
- R3: `take_irq` is 1 in a cycle only when all of these hold: `instr_done` is 1, `gie` is 1, the unit is not servicing, and some bit of `pend & src_en` is 1.
- R4: Priority is external, then timer 1, then timer 2. `vec_addr` during a take is 2^PAGE_W plus 0 (external), 4 (timer 1) or 6 (timer 2).
- R5: A take clears only the serviced source's `pend` bit. The other bits keep their values.
- R6: After a take, `gie` is 0.
- R7: After a take, `ret_addr` holds the `cur_pc` value present in the take cycle.
- R8: The `ctx_in` value present at a take is held. An RTI while servicing pulses `ctx_restore` and shows that value on `ctx_out`. An RTI while not servicing leaves `ctx_restore` at 0.
- R9: After an EI strobe, `gie` stays 0 through the EI's own boundary. It becomes 1 after the next `instr_done`, so an interrupt is first accepted at the boundary after that.
- R10: DI makes `gie` 0 from the next cycle. DI in the same cycle as EI wins.
- R11: Each `clr_req` bit clears its flag. A source event in the same cycle as its clear leaves the flag set.
- R12: While servicing, no take occurs, even with `gie`, `pend` and `src_en` all active, until RTI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External request pin |
| edge_sel | input | 1 | 0 selects rising edge, 1 selects falling edge |
| tmr1_uf | input | 1 | Timer 1 underflow pulse |
| tmr2_uf | input | 1 | Timer 2 underflow pulse |
| src_en | input | 3 | Per-source enable (bit 0 ext, 1 timer 1, 2 timer 2) |
| clr_req | input | 3 | Software clear of request flags |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| rti_stb | input | 1 | Return-from-interrupt strobe |
| instr_done | input | 1 | Instruction boundary strobe |
| cur_pc | input | PC_W | Current program counter |
| ctx_in | input | CTX_W | Core context {dp, carry, skip, A, B} |
| take_irq | output | 1 | Interrupt accepted this cycle |
| vec_addr | output | PC_W | Vector address for the accepted source |
| ret_addr | output | PC_W | Return-address register |
| ctx_out | output | CTX_W | Saved context |
| ctx_restore | output | 1 | Restore strobe for the core |
| gie | output | 1 | Global enable |
| pend | output | 3 | Request flags |
| in_isr | output | 1 | Unit is servicing an interrupt |

## Verification
On every cycle, the assertions check the following. A take happens only at a boundary with global enable set and outside service. The external source's vector wins whenever that source is eligible. Global enable is low after a take or DI, and it rises only after a boundary. The return address matches the PC from the take cycle, and no take occurs while servicing. Only the bench scenarios can show some behaviours: the full priority order across enable masks, which flags survive a take, the one-instruction EI delay, the falling-edge pin mode, the set-over-clear rule, and the context value handed back on RTI.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
    localparam int NSRC = 3;

    typedef enum logic [1:0] {GE_OFF, GE_ARMED, GE_ON} ge_state_e;
    typedef enum logic {CTL_RUN, CTL_ISR} ctl_state_e;

    // offset of each source's entry inside the vector page
    function automatic logic [2:0] vec_offset(input logic [1:0] idx);
        case (idx)
            2'd0:    return 3'd0;
            2'd1:    return 3'd4;
            default: return 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/irq_req_flags.sv
`timescale 1ns/1ps
module irq_req_flags #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_in,
    input  logic            edge_sel,
    input  logic            tmr1_uf,
    input  logic            tmr2_uf,
    input  logic [NSRC-1:0] clr_sw,
    input  logic [NSRC-1:0] clr_take,
    output logic [NSRC-1:0] pend
);
    logic            pin_q;
    logic            pin_evt;
    logic [NSRC-1:0] set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_in;
    end

    always_comb begin
        pin_evt = edge_sel ? (pin_q & ~pin_in) : (~pin_q & pin_in);
        set_vec = '0;
        set_vec[0] = pin_evt;
        set_vec[1] = tmr1_uf;
        set_vec[2] = tmr2_uf;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pend[g] <= 1'b0;
            else if (set_vec[g])                 pend[g] <= 1'b1;
            else if (clr_sw[g] || clr_take[g])   pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_gie_fsm.sv
`timescale 1ns/1ps
module irq_gie_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ei_stb,
    input  logic di_stb,
    input  logic instr_done,
    input  logic take,
    output logic gie
);
    ge_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GE_OFF:   if (ei_stb) state_d = GE_ARMED;
            GE_ARMED: if (!ei_stb && instr_done) state_d = GE_ON;
            GE_ON:    state_d = GE_ON;
            default:  state_d = GE_OFF;
        endcase
        if (take || di_stb) state_d = GE_OFF;
    end

    always_comb begin
        gie = (state_q == GE_ON);
    end
endmodule

// File: rtl/irq_ctx_store.sv
`timescale 1ns/1ps
module irq_ctx_store #(
    parameter int PC_W  = 14,
    parameter int CTX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [CTX_W-1:0] ctx_in,
    output logic [PC_W-1:0]  ret_addr,
    output logic [CTX_W-1:0] ctx_held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_addr <= '0;
            ctx_held <= '0;
        end else if (save) begin
            ret_addr <= pc_in;
            ctx_held <= ctx_in;
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
`timescale 1ns/1ps
module irq_vector_unit
    import irq_pkg::*;
#(
    parameter int PC_W   = 14,
    parameter int PAGE_W = 7,
    parameter int DP_W   = 6,
    parameter int REG_W  = 4,
    localparam int CTX_W = DP_W + 2 + 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             edge_sel,
    input  logic             tmr1_uf,
    input  logic             tmr2_uf,
    input  logic [2:0]       src_en,
    input  logic [2:0]       clr_req,
    input  logic             ei_stb,
    input  logic             di_stb,
    input  logic             rti_stb,
    input  logic             instr_done,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [CTX_W-1:0] ctx_in,
    output logic             take_irq,
    output logic [PC_W-1:0]  vec_addr,
    output logic [PC_W-1:0]  ret_addr,
    output logic [CTX_W-1:0] ctx_out,
    output logic             ctx_restore,
    output logic             gie,
    output logic [2:0]       pend,
    output logic             in_isr
);
    localparam logic [PC_W-1:0] PAGE_BASE = PC_W'(1) << PAGE_W;

    ctl_state_e      ctl_q, ctl_d;
    logic [1:0]      win_idx;
    logic            win_any;
    logic [NSRC-1:0] clr_take;

    irq_req_flags #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_sel(edge_sel),
        .tmr1_uf(tmr1_uf), .tmr2_uf(tmr2_uf), .clr_sw(clr_req),
        .clr_take(clr_take), .pend(pend)
    );

    irq_gie_fsm u_gie (
        .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb),
        .instr_done(instr_done), .take(take_irq), .gie(gie)
    );

    irq_ctx_store #(.PC_W(PC_W), .CTX_W(CTX_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .save(take_irq), .pc_in(cur_pc),
        .ctx_in(ctx_in), .ret_addr(ret_addr), .ctx_held(ctx_out)
    );

    // fixed priority: lowest index wins
    always_comb begin
        win_idx = 2'd0;
        win_any = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i] && src_en[i]) begin
                win_idx = 2'(i);
                win_any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RUN;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_RUN: if (take_irq) ctl_d = CTL_ISR;
            CTL_ISR: if (rti_stb)  ctl_d = CTL_RUN;
            default: ctl_d = CTL_RUN;
        endcase
    end

    always_comb begin
        in_isr      = (ctl_q == CTL_ISR);
        take_irq    = (ctl_q == CTL_RUN) && instr_done && gie && win_any;
        vec_addr    = PAGE_BASE | PC_W'(vec_offset(win_idx));
        ctx_restore = (ctl_q == CTL_ISR) && rti_stb;
        clr_take    = '0;
        if (take_irq) clr_take[win_idx] = 1'b1;
    end
endmodule

// File: rtl/irq_vector_unit_chk.sv
`timescale 1ns/1ps
module irq_vector_unit_chk #(
    parameter int PC_W   = 14,
    parameter int PAGE_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_done,
    input logic            di_stb,
    input logic            rti_stb,
    input logic [PC_W-1:0] cur_pc,
    input logic [2:0]      src_en,
    input logic            take_irq,
    input logic [PC_W-1:0] vec_addr,
    input logic [PC_W-1:0] ret_addr,
    input logic            gie,
    input logic [2:0]      pend,
    input logic            ctx_restore,
    input logic            in_isr
);
    localparam logic [PC_W-1:0] BASE = PC_W'(1) << PAGE_W;

    a_r3_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (instr_done && gie && !in_isr));
    a_r4_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && pend[0] && src_en[0]) |-> (vec_addr == BASE));
    a_r6_gie_drops: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !gie);
    a_r7_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (ret_addr == $past(cur_pc)));
    a_r9_ei_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie) |-> $past(instr_done));
    a_r10_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
        di_stb |=> !gie);
    a_r12_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (in_isr && !take_irq));
    a_r8_restore_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_restore && rti_stb) |=> !in_isr);
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .di_stb(di_stb),
    .rti_stb(rti_stb), .cur_pc(cur_pc), .src_en(src_en), .take_irq(take_irq),
    .vec_addr(vec_addr), .ret_addr(ret_addr), .gie(gie), .pend(pend),
    .ctx_restore(ctx_restore), .in_isr(in_isr)
);

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
    localparam int PC_W = 14;
    localparam int CTX_W = 16;
    localparam int BASE = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_in = 1'b0, edge_sel = 1'b0, tmr1_uf = 1'b0, tmr2_uf = 1'b0;
    logic [2:0] src_en = '0, clr_req = '0;
    logic ei_stb = 1'b0, di_stb = 1'b0, rti_stb = 1'b0, instr_done = 1'b0;
    logic [PC_W-1:0] cur_pc = '0;
    logic [CTX_W-1:0] ctx_in = '0;
    logic take_irq, ctx_restore, gie, in_isr;
    logic [PC_W-1:0] vec_addr, ret_addr;
    logic [CTX_W-1:0] ctx_out;
    logic [2:0] pend;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_sel(edge_sel),
        .tmr1_uf(tmr1_uf), .tmr2_uf(tmr2_uf), .src_en(src_en), .clr_req(clr_req),
        .ei_stb(ei_stb), .di_stb(di_stb), .rti_stb(rti_stb), .instr_done(instr_done),
        .cur_pc(cur_pc), .ctx_in(ctx_in), .take_irq(take_irq), .vec_addr(vec_addr),
        .ret_addr(ret_addr), .ctx_out(ctx_out), .ctx_restore(ctx_restore),
        .gie(gie), .pend(pend), .in_isr(in_isr)
    );

    always #5 clk = ~clk;

    // {raise[2:0], en[2:0], take, offset[2:0], pend_after[2:0]}
    localparam logic [12:0] VEC [8] = '{
        {3'b001, 3'b111, 1'b1, 3'd0, 3'b000},
        {3'b010, 3'b111, 1'b1, 3'd4, 3'b000},
        {3'b100, 3'b111, 1'b1, 3'd6, 3'b000},
        {3'b111, 3'b111, 1'b1, 3'd0, 3'b110},
        {3'b110, 3'b111, 1'b1, 3'd4, 3'b100},
        {3'b111, 3'b110, 1'b1, 3'd4, 3'b101},
        {3'b111, 3'b100, 1'b1, 3'd6, 3'b011},
        {3'b011, 3'b100, 1'b0, 3'd0, 3'b011}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        ei_stb = 0; di_stb = 0; rti_stb = 0; instr_done = 0;
        tmr1_uf = 0; tmr2_uf = 0; clr_req = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 gie", gie, 0);
        chk("R1 pend", pend, 0);
        chk("R1 take", take_irq, 0);
        chk("R1 restore", ctx_restore, 0);

        // table walk: R2 R3 R4 R5 R6 R9
        for (int k = 0; k < 8; k++) begin
            logic [12:0] v;
            v = VEC[k];
            src_en = '0; clr_req = 3'b111; step();
            pin_in = v[10]; tmr1_uf = v[11]; tmr2_uf = v[12]; step();
            pin_in = 0;
            chk("R2 flags latch while disabled", pend, v[12:10]);
            ei_stb = 1; step();
            chk("R9 gie still low after EI", gie, 0);
            instr_done = 1; step();
            chk("R9 gie high after next boundary", gie, 1);
            src_en = v[9:7]; instr_done = 1; #1;
            chk("R3 take", take_irq, v[6]);
            if (v[6]) chk("R4 vector", vec_addr, BASE + v[5:3]);
            step();
            chk("R5 pend after", pend, v[2:0]);
            if (v[6]) begin
                chk("R6 gie cleared", gie, 0);
                rti_stb = 1; step();
            end else begin
                di_stb = 1; step();
            end
        end

        // R2 falling-edge mode
        src_en = '0; clr_req = 3'b111; edge_sel = 1; step();
        pin_in = 1; step();
        chk("R2 rising ignored in falling mode", pend, 0);
        pin_in = 0; step();
        chk("R2 falling sets ext", pend, 3'b001);

        // R7 R8 R12 context and nesting
        ei_stb = 1; step();
        instr_done = 1; step();
        src_en = 3'b001; cur_pc = 14'h1A5; ctx_in = 16'hBEEF; instr_done = 1; #1;
        chk("R3 take ext", take_irq, 1);
        step();
        chk("R7 return address", ret_addr, 14'h1A5);
        chk("R12 in service", in_isr, 1);
        ctx_in = 16'h1234; cur_pc = 14'h003;
        ei_stb = 1; step();
        instr_done = 1; step();
        chk("R9 gie on inside service", gie, 1);
        pin_in = 1; step();
        pin_in = 0; step();
        chk("R12 ext pending again", pend[0], 1);
        instr_done = 1; #1;
        chk("R12 no take while servicing", take_irq, 0);
        step();
        rti_stb = 1; #1;
        chk("R8 restore pulse", ctx_restore, 1);
        chk("R8 saved context", ctx_out, 16'hBEEF);
        step();
        rti_stb = 1; #1;
        chk("R8 rti outside service ignored", ctx_restore, 0);
        step();
        di_stb = 1; step();
        chk("R10 di clears gie", gie, 0);

        // R9 one-instruction delay, ext still pending and enabled
        ei_stb = 1; instr_done = 1; #1;
        chk("R9 no take on EI boundary", take_irq, 0);
        step();
        instr_done = 1; #1;
        chk("R9 no take on following boundary", take_irq, 0);
        step();
        instr_done = 1; #1;
        chk("R9 take one boundary later", take_irq, 1);
        step();
        rti_stb = 1; step();

        // R10 DI beats EI
        ei_stb = 1; di_stb = 1; step();
        chk("R10 di wins over ei", gie, 0);
        instr_done = 1; step();
        chk("R10 gie stays low", gie, 0);

        // R11 software clear
        clr_req = 3'b111; step();
        tmr1_uf = 1; clr_req = 3'b010; step();
        chk("R11 set wins over clear", pend, 3'b010);
        tmr2_uf = 1; step();
        clr_req = 3'b010; step();
        chk("R11 clear single flag", pend, 3'b100);

        finish_run();
    end
endmodule